// File: doc/BRIEF.md
# Oscillator Enable and Stabilization-Wait Controller

This block holds one 8-bit control register for three clock sources: an internal oscillator, a high-speed oscillator and a low-speed oscillator. Software reads and writes the register over a plain address / write-enable / write-data / read-data bus. The register holds one enable bit per source and a wait-length code for each of the two timed sources.

Oscillator cycles are modelled as single-cycle tick strobes in the bus clock domain. Each timed source holds its ready flag low after oscillation starts, until it has seen the selected number of its own ticks. Oscillation starts when reset is released, when the sleep input drops, or when software sets the enable bit. Sleep stops every source and clears every ready flag. A CPU-release output stays low after reset until the internal oscillator first becomes ready.

There is no streaming data path. All pins are plain control and status signals with no valid/ready handshake and no back-pressure. Register reads are combinational on the address. Writes take effect at the clock edge where `wr_en` is high.

Top module: `osc_wait_ctrl`

## Requirements
- R1: The register sits at address `REG_ADDR` (default 1). Bit 0 enables the high-speed source, bit 1 the low-speed source and bit 2 the internal source. Bits 5:4 hold the high-speed wait code and bits 7:6 the internal wait code. A write with `wr_en` high at any other address changes nothing, and a read of any other address returns 0.
- R2: After reset the register reads 0x04: the internal source is enabled, the other two are disabled, and both wait codes are 0.
- R3: Bit 3 always reads 0, and a value written to it is discarded.
- R4: The internal wait length is 8 << (3 - code) ticks, so code 3 gives 8, code 2 gives 16, code 1 gives 32 and code 0 gives 64.
- R5: The high-speed wait length is 128 << (3 - code) ticks, so code 3 gives 128, code 2 gives 256, code 1 gives 512 and code 0 gives 1024.
- R6: A start happens on the first clock edge where the source is enabled and `sleep` is low. This occurs after reset release, after sleep release, or after its enable bit is set. A tick in that start cycle is not counted. From then on, ready goes high at the edge that samples the Nth tick of that source, where N is the wait length. Ticks of other sources and bus-clock cycles do not count.
- R7: Clearing a timed source's enable bit drops its ready flag at the next edge and clears its count. Setting the bit again starts a complete wait using the code held at that moment.
- R8: Changing a wait code while that source is counting does not change the wait in progress.
- R9: While `sleep` is high, all three ready flags are low from the next edge on, and ticks are not counted. When `sleep` falls, every enabled timed source starts a new full wait.
- R10: The low-speed ready flag rises at the edge that samples the first low-speed tick while that source is enabled and awake. It falls at the edge after the enable is cleared or `sleep` rises.
- R11: `cpu_release` is low from reset until the edge after `int_ready` is first high. It then stays high until the next reset, whatever sleep or the enables do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational on `addr` |
| sleep | input | 1 | Stops all oscillators while high |
| int_tick | input | 1 | One pulse per internal-oscillator cycle |
| hs_tick | input | 1 | One pulse per high-speed-oscillator cycle |
| ls_tick | input | 1 | One pulse per low-speed-oscillator cycle |
| int_ready | output | 1 | Internal clock stable and delivered |
| hs_ready | output | 1 | High-speed clock stable and delivered |
| ls_ready | output | 1 | Low-speed clock delivered |
| cpu_release | output | 1 | CPU may run |

## Verification
The assertions check the following on every cycle:
- The reserved bit reads zero and unselected addresses read zero.
- Every ready rise coincides with a tick of its own source.
- Sleep and a cleared high-speed enable force their ready flags low.
- `cpu_release` never rises without `int_ready` and never falls.

The bench scenarios alone show the exact wait lengths for every code of both timed sources. They also show that a code change during a count is ignored, that a fresh wait starts after reset, after enable and after sleep release, and that a write to another address leaves the register unchanged.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;

  typedef struct packed {
    logic [1:0] int_code;
    logic [1:0] hs_code;
    logic       rsvd;
    logic       int_en;
    logic       ls_en;
    logic       hs_en;
  } ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h04;
  localparam logic [7:0] RSVD_MASK = 8'h08;

endpackage

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_wait_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output ctl_t              ctl_q,
  output logic [7:0]        rd_data,
  output logic              addr_hit
);

  assign addr_hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= ctl_t'(CTL_RESET);
    end else if (wr_en && addr_hit) begin
      ctl_q <= ctl_t'(wr_data & ~RSVD_MASK);
    end
  end

  assign rd_data = addr_hit ? ctl_q : 8'h00;

endmodule

// File: rtl/osc_stab_counter.sv
module osc_stab_counter #(
  parameter int BASE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] code,
  output logic       ready
);

  localparam int MAX_LOG2 = BASE_LOG2 + 3;
  localparam int CNT_W    = MAX_LOG2 + 1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN3 = ONE << BASE_LOG2;
  localparam logic [CNT_W-1:0] LEN2 = ONE << (BASE_LOG2 + 1);
  localparam logic [CNT_W-1:0] LEN1 = ONE << (BASE_LOG2 + 2);
  localparam logic [CNT_W-1:0] LEN0 = ONE << MAX_LOG2;

  logic             started;
  logic [1:0]       code_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             rdy_q;

  always_comb begin
    unique case (code_q)
      2'd3:    target = LEN3;
      2'd2:    target = LEN2;
      2'd1:    target = LEN1;
      default: target = LEN0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      code_q  <= 2'd0;
      cnt     <= '0;
      rdy_q   <= 1'b0;
    end else if (!run) begin
      started <= 1'b0;
      cnt     <= '0;
      rdy_q   <= 1'b0;
    end else if (!started) begin
      started <= 1'b1;
      code_q  <= code;
      cnt     <= '0;
    end else if (!rdy_q && tick) begin
      cnt <= cnt + ONE;
      if (cnt == target - ONE) rdy_q <= 1'b1;
    end
  end

  assign ready = rdy_q;

endmodule

// File: rtl/osc_ls_ready.sv
module osc_ls_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic ready
);

  logic rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdy_q <= 1'b0;
    else if (!run)    rdy_q <= 1'b0;
    else if (tick)    rdy_q <= 1'b1;
  end

  assign ready = rdy_q;

endmodule

// File: rtl/osc_wait_ctrl.sv
module osc_wait_ctrl
  import osc_wait_pkg::*;
#(
  parameter int                ADDR_W        = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR      = 1,
  parameter int                INT_BASE_LOG2 = 3,
  parameter int                HS_BASE_LOG2  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              sleep,
  input  logic              int_tick,
  input  logic              hs_tick,
  input  logic              ls_tick,
  output logic              int_ready,
  output logic              hs_ready,
  output logic              ls_ready,
  output logic              cpu_release
);

  ctl_t ctl_q;
  logic addr_hit;
  logic hs_en_w;
  logic int_run, hs_run, ls_run;
  logic rel_q;

  osc_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .rd_data(rd_data), .addr_hit(addr_hit)
  );

  assign hs_en_w = ctl_q.hs_en;
  assign int_run = ctl_q.int_en & ~sleep;
  assign hs_run  = ctl_q.hs_en  & ~sleep;
  assign ls_run  = ctl_q.ls_en  & ~sleep;

  osc_stab_counter #(.BASE_LOG2(INT_BASE_LOG2)) u_int_wait (
    .clk(clk), .rst_n(rst_n), .run(int_run), .tick(int_tick),
    .code(ctl_q.int_code), .ready(int_ready)
  );

  osc_stab_counter #(.BASE_LOG2(HS_BASE_LOG2)) u_hs_wait (
    .clk(clk), .rst_n(rst_n), .run(hs_run), .tick(hs_tick),
    .code(ctl_q.hs_code), .ready(hs_ready)
  );

  osc_ls_ready u_ls (
    .clk(clk), .rst_n(rst_n), .run(ls_run), .tick(ls_tick), .ready(ls_ready)
  );

  // CPU hold: set once the internal source is first ready, cleared only by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_q | int_ready;
  end

  assign cpu_release = rel_q;

endmodule

// File: rtl/osc_wait_chk.sv
module osc_wait_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_hit,
  input logic [7:0] rd_data,
  input logic       sleep,
  input logic       hs_en,
  input logic       int_tick,
  input logic       hs_tick,
  input logic       ls_tick,
  input logic       int_ready,
  input logic       hs_ready,
  input logic       ls_ready,
  input logic       cpu_release
);

  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] == 1'b0); // R3

  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> rd_data == 8'h00); // R1

  AST_INT_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_ready) |-> $past(int_tick)); // R6

  AST_HS_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_ready) |-> $past(hs_tick)); // R6

  AST_SLEEP_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!int_ready && !hs_ready && !ls_ready)); // R9

  AST_HS_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |=> !hs_ready); // R7

  AST_LS_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_ready) |-> $past(ls_tick)); // R10

  AST_CPU_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |=> cpu_release); // R11

  AST_CPU_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_release) |-> $past(int_ready)); // R11

endmodule

bind osc_wait_ctrl osc_wait_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .rd_data(rd_data),
  .sleep(sleep), .hs_en(hs_en_w), .int_tick(int_tick), .hs_tick(hs_tick),
  .ls_tick(ls_tick), .int_ready(int_ready), .hs_ready(hs_ready),
  .ls_ready(ls_ready), .cpu_release(cpu_release)
);

// File: tb/tb_osc_wait_ctrl.sv
module tb_osc_wait_ctrl;

  localparam int         ADDR_W = 4;
  localparam logic [3:0] RA     = 4'd1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = RA;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sleep = 1'b0;
  logic       int_tick = 1'b0, hs_tick = 1'b0, ls_tick = 1'b0;
  logic       int_ready, hs_ready, ls_ready, cpu_release;

  int n_pass = 0, n_total = 0;
  int int_sent = 0, hs_sent = 0;
  int int_q[$];
  int hs_q[$];
  logic int_prev = 1'b0, hs_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  osc_wait_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep(sleep), .int_tick(int_tick), .hs_tick(hs_tick),
    .ls_tick(ls_tick), .int_ready(int_ready), .hs_ready(hs_ready),
    .ls_ready(ls_ready), .cpu_release(cpu_release)
  );

  task automatic check(string req, int act, int exp);
    n_total++;
    if (act == exp) n_pass++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  function automatic int int_len(int code);
    return 8 << (3 - code);
  endfunction

  function automatic int hs_len(int code);
    return 128 << (3 - code);
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; addr = RA;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, int exp);
    @(negedge clk); addr = a; #1;
    check(req, int'(rd_data), exp);
    addr = RA;
  endtask

  task automatic pulse_int(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); int_tick = 1'b1; int_sent++;
      @(negedge clk); int_tick = 1'b0;
    end
  endtask

  task automatic pulse_hs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hs_tick = 1'b1; hs_sent++;
      @(negedge clk); hs_tick = 1'b0;
    end
  endtask

  task automatic pulse_ls(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ls_tick = 1'b1;
      @(negedge clk); ls_tick = 1'b0;
    end
  endtask

  // Monitor: each ready rise pops the expected tick count for its source
  always @(negedge clk) begin
    if (rst_n) begin
      if (int_ready && !int_prev) begin
        if (int_q.size() == 0) check("R6 unexpected int_ready rise", int_sent, -1);
        else check("R4/R6 internal wait length", int_sent, int_q.pop_front());
      end
      if (hs_ready && !hs_prev) begin
        if (hs_q.size() == 0) check("R6 unexpected hs_ready rise", hs_sent, -1);
        else check("R5/R6 high-speed wait length", hs_sent, hs_q.pop_front());
      end
    end
    int_prev = int_ready;
    hs_prev  = hs_ready;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check("watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    rd_chk("R2 reset value", RA, 8'h04);
    check("R11 cpu held in reset", int'(cpu_release), 0);
    int_sent = 0;
    int_q.push_back(64);
    @(negedge clk); rst_n = 1'b1;
    pulse_int(63);
    check("R11 cpu held before wait", int'(cpu_release), 0);
    check("R4 int not ready at 63", int'(int_ready), 0);
    pulse_int(1);
    @(negedge clk);
    check("R11 cpu released", int'(cpu_release), 1);

    // R1/R3: address decode and reserved bit
    wr(RA + 4'd1, 8'hFF);
    rd_chk("R1 other-address write ignored", RA, 8'h04);
    rd_chk("R1 other address reads zero", RA + 4'd1, 0);
    wr(RA, 8'h3D);
    rd_chk("R3 reserved bit dropped", RA, 8'h35);
    check("R7 int ready kept", int'(int_ready), 1);

    // R5: code 3
    hs_sent = 0; hs_q.push_back(hs_len(3));
    pulse_hs(130);

    // R7: disable then re-enable with code 2
    wr(RA, 8'h34);
    @(negedge clk);
    check("R7 hs ready drops on disable", int'(hs_ready), 0);
    wr(RA, 8'h25);
    hs_sent = 0; hs_q.push_back(hs_len(2));
    pulse_hs(260);

    // R8: code change mid-count
    wr(RA, 8'h24);
    wr(RA, 8'h15);
    hs_sent = 0; hs_q.push_back(hs_len(1));
    pulse_hs(100);
    wr(RA, 8'h35);
    pulse_hs(415);
    check("R8 hs ready after full wait", int'(hs_ready), 1);

    // R9: sleep
    @(negedge clk); sleep = 1'b1;
    @(negedge clk);
    check("R9 int ready cleared", int'(int_ready), 0);
    check("R9 hs ready cleared", int'(hs_ready), 0);
    check("R11 cpu stays released", int'(cpu_release), 1);
    pulse_int(80); pulse_hs(140);
    int_sent = 0; hs_sent = 0;
    int_q.push_back(int_len(0)); hs_q.push_back(hs_len(3));
    @(negedge clk); sleep = 1'b0;
    pulse_int(70);
    pulse_hs(130);

    // R5: code 0
    wr(RA, 8'h04);
    wr(RA, 8'h05);
    hs_sent = 0; hs_q.push_back(hs_len(0));
    pulse_hs(1030);

    // R4: remaining internal codes
    for (int c = 3; c >= 1; c--) begin
      wr(RA, 8'h00);
      wr(RA, 8'(c << 6) | 8'h04);
      int_sent = 0; int_q.push_back(int_len(c));
      pulse_int(int_len(c) + 2);
    end
    check("R11 cpu unaffected by disable", int'(cpu_release), 1);

    // R10: low-speed
    pulse_ls(2);
    check("R10 ls ignored while disabled", int'(ls_ready), 0);
    wr(RA, 8'h06);
    @(negedge clk);
    check("R10 ls waits for tick", int'(ls_ready), 0);
    pulse_ls(1);
    check("R10 ls ready on first tick", int'(ls_ready), 1);
    wr(RA, 8'h04);
    @(negedge clk);
    check("R10 ls drops on disable", int'(ls_ready), 0);

    repeat (4) @(negedge clk);
    check("R6 all expected rises seen (int)", int_q.size(), 0);
    check("R6 all expected rises seen (hs)", hs_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule